// File: doc/BRIEF.md
# Programmable YCbCr to RGB Converter

This block turns a stream of 10-bit luma/chroma pixels into 10-bit red, green and blue samples. Each output channel is a weighted sum of the three inputs after a per-input offset has been removed. The nine weights and three offsets are signed values held in twelve programmable coefficient registers. A weight of 1024 means unity gain. Software picks the colour standard and the range (limited or full) by loading a coefficient set. After reset the registers hold the limited-range standard-definition set.

Pixels enter and leave on valid/ready handshakes. The datapath has two registered stages: the first removes the offsets and forms the nine products, and the second adds them, rounds, scales and clamps. A configuration port writes one coefficient per cycle into a shadow copy. The shadow copy is moved into the working copy only when the pipeline is empty, or on a frame-start strobe. A pixel in flight is therefore never converted with a mix of old and new coefficients.

Top module: `ycbcr_rgb_xform`

## Requirements
- R1: After reset, inReady is 1, outValid is 0, and the active set is the limited-range standard-definition set: matrix rows (1192,0,1634), (1192,-401,-832), (1192,2066,0) and offsets Y=64, Cb=512, Cr=512.
- R2: Each output channel row r equals floor((sum over inputs k of C[3r+k]*(in_k - O_k) + 512) / 1024). The inputs are k=0 Y, k=1 Cb, k=2 Cr. The offsets are O_Y=C[9], O_Cb=C[10], O_Cr=C[11]. Row 0 is R, row 1 is G and row 2 is B.
- R3: A result below 0 is output as 0, and a result above 1023 is output as 1023.
- R4: Coefficients are 14-bit two's complement. A written value with bit 13 set acts as a negative weight or offset.
- R5: The write address selects coefficient index C[addr]. Indices 0..8 are the matrix in row order (R, G, B), with columns Y, Cb, Cr inside each row. Indices 9..11 are the Y, Cb and Cr offsets. Writes to addresses 12..15 change nothing.
- R6: A written coefficient takes effect only at a clock edge where both pipeline stages are empty, or where frameStart is high. A pixel accepted at that same edge still uses the previous set. A pixel accepted at any later edge uses the new set.
- R7: A pixel accepted at clock edge k appears on the outputs with outValid high after edge k+1, provided outReady was high.
- R8: While outValid is 1 and outReady is 0, the outputs hold their values and no pixel is lost. inReady is 0 whenever both stages are full and the output is stalled.
- R9: With outReady held high, one pixel is accepted and one is delivered on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Coefficient write strobe |
| cfgAddr | input | 4 | Coefficient index |
| cfgData | input | 14 | Signed coefficient value |
| frameStart | input | 1 | Frame boundary; allows a pending set to take effect |
| inValid | input | 1 | Input pixel valid |
| inReady | output | 1 | Converter can accept a pixel |
| inY | input | 10 | Luma |
| inCb | input | 10 | Blue-difference chroma |
| inCr | input | 10 | Red-difference chroma |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Downstream accepts the pixel |
| outR | output | 10 | Red |
| outG | output | 10 | Green |
| outB | output | 10 | Blue |

## Verification
Assertions run on every cycle and cover the handshake and the update gating. They check that stalled outputs hold their value, that a full stalled pipeline refuses input, and that a stage one pixel moves on when stage two is free. They also check that the working coefficients change only on a permitted commit, and that a commit happens only when the pipeline is idle or at frame start. The arithmetic needs the bench's directed scenarios, which compare results against an independent model. Those scenarios cover rounding, clamping, negative weights, the register order, the exact pixel at which a new set takes effect in a busy stream, and ignored addresses.

// File: rtl/ycx_pkg.sv
package ycx_pkg;
  localparam int COEF_W = 14;
  localparam int N_CH   = 3;
  localparam int N_MAT  = N_CH * N_CH;
  localparam int N_COEF = N_MAT + N_CH;

  typedef logic [N_COEF-1:0][COEF_W-1:0] coefSet_t;

  typedef struct packed {
    logic commit;
  } ctrlStrb_t;

  function automatic coefSet_t defaultSet();
    coefSet_t s;
    s[0]  = COEF_W'(1192);
    s[1]  = COEF_W'(0);
    s[2]  = COEF_W'(1634);
    s[3]  = COEF_W'(1192);
    s[4]  = COEF_W'(-401);
    s[5]  = COEF_W'(-832);
    s[6]  = COEF_W'(1192);
    s[7]  = COEF_W'(2066);
    s[8]  = COEF_W'(0);
    s[9]  = COEF_W'(64);
    s[10] = COEF_W'(512);
    s[11] = COEF_W'(512);
    return s;
  endfunction
endpackage

// File: rtl/ycx_ctrl.sv
module ycx_ctrl
  import ycx_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [COEF_W-1:0] cfgData,
  input  logic              frameStart,
  input  logic              pipeIdle,
  output coefSet_t          shadowSet,
  output ctrlStrb_t         strb
);
  localparam logic [ADDR_W-1:0] LastIdx = ADDR_W'(N_COEF - 1);

  logic addrOk;
  logic dirty;

  assign addrOk      = cfgAddr <= LastIdx;
  assign strb.commit = dirty && (pipeIdle || frameStart);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowSet <= defaultSet();
      dirty     <= 1'b0;
    end else begin
      if (cfgWrEn && addrOk) shadowSet[cfgAddr] <= cfgData;
      if (cfgWrEn && addrOk) dirty <= 1'b1;
      else if (strb.commit)  dirty <= 1'b0;
    end
  end

  AST_COMMIT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (pipeIdle || frameStart)); // R6
  AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !addrOk) |=> $stable(shadowSet)); // R5
endmodule

// File: rtl/ycx_datapath.sv
module ycx_datapath
  import ycx_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int FRAC_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  coefSet_t         shadowSet,
  input  logic             inValid,
  output logic             inReady,
  input  logic [PIX_W-1:0] inY,
  input  logic [PIX_W-1:0] inCb,
  input  logic [PIX_W-1:0] inCr,
  output logic             outValid,
  input  logic             outReady,
  output logic [PIX_W-1:0] outR,
  output logic [PIX_W-1:0] outG,
  output logic [PIX_W-1:0] outB,
  output logic             pipeIdle
);
  localparam int DIFF_W = COEF_W + 1;
  localparam int PROD_W = DIFF_W + COEF_W;
  localparam int SUM_W  = PROD_W + 2;
  localparam logic signed [SUM_W-1:0] RoundK = SUM_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [SUM_W-1:0] MaxV   = SUM_W'((1 << PIX_W) - 1);

  coefSet_t activeSet;
  logic s1Valid, s2Valid, s1Load, s2Load;
  logic [N_CH-1:0][PIX_W-1:0] pixIn;
  logic signed [DIFF_W-1:0] diffV [N_CH];
  logic signed [PROD_W-1:0] prodNext [N_CH][N_CH];
  logic signed [PROD_W-1:0] prodQ    [N_CH][N_CH];
  logic [PIX_W-1:0] chanNext [N_CH];
  logic [PIX_W-1:0] chanQ    [N_CH];

  assign pixIn    = {inCr, inCb, inY};
  assign s2Load   = s1Valid && (!s2Valid || outReady);
  assign inReady  = !s1Valid || s2Load;
  assign s1Load   = inValid && inReady;
  assign pipeIdle = !s1Valid && !s2Valid;
  assign outValid = s2Valid;
  assign outR     = chanQ[0];
  assign outG     = chanQ[1];
  assign outB     = chanQ[2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeSet <= defaultSet();
      s1Valid   <= 1'b0;
      s2Valid   <= 1'b0;
    end else begin
      if (strb.commit) activeSet <= shadowSet;
      if (s1Load) s1Valid <= 1'b1;
      else if (s2Load) s1Valid <= 1'b0;
      if (s2Load) s2Valid <= 1'b1;
      else if (outReady) s2Valid <= 1'b0;
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_diff
    logic signed [COEF_W-1:0] offC;
    assign offC     = $signed(activeSet[N_MAT + c]);
    assign diffV[c] = DIFF_W'($signed({1'b0, pixIn[c]})) - DIFF_W'(offC);
  end

  for (genvar r = 0; r < N_CH; r++) begin : g_row
    for (genvar c = 0; c < N_CH; c++) begin : g_col
      logic signed [COEF_W-1:0] wC;
      assign wC = $signed(activeSet[r*N_CH + c]);
      assign prodNext[r][c] = PROD_W'(diffV[c]) * PROD_W'(wC);
      always_ff @(posedge clk) begin
        if (s1Load) prodQ[r][c] <= prodNext[r][c];
      end
    end

    logic signed [SUM_W-1:0] sumV, shiftV;
    assign sumV   = SUM_W'(prodQ[r][0]) + SUM_W'(prodQ[r][1])
                  + SUM_W'(prodQ[r][2]) + RoundK;
    assign shiftV = sumV >>> FRAC_W;

    always_comb begin
      if (sumV[SUM_W-1])      chanNext[r] = '0;
      else if (shiftV > MaxV) chanNext[r] = '1;
      else                    chanNext[r] = shiftV[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (s2Load) chanQ[r] <= chanNext[r];
    end
  end

  AST_STALL_HOLDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid); // R8
  AST_STALL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(outR) && $stable(outG) && $stable(outB))); // R8
  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && s2Valid && !outReady) |-> !inReady); // R8
  AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && !s2Valid) |=> outValid); // R7
  AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(activeSet)); // R6
endmodule

// File: rtl/ycbcr_rgb_xform.sv
module ycbcr_rgb_xform
  import ycx_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int FRAC_W = 10,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [COEF_W-1:0] cfgData,
  input  logic              frameStart,
  input  logic              inValid,
  output logic              inReady,
  input  logic [PIX_W-1:0]  inY,
  input  logic [PIX_W-1:0]  inCb,
  input  logic [PIX_W-1:0]  inCr,
  output logic              outValid,
  input  logic              outReady,
  output logic [PIX_W-1:0]  outR,
  output logic [PIX_W-1:0]  outG,
  output logic [PIX_W-1:0]  outB
);
  coefSet_t  shadowSet;
  ctrlStrb_t strb;
  logic      pipeIdle;

  ycx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .frameStart(frameStart), .pipeIdle(pipeIdle),
    .shadowSet(shadowSet), .strb(strb)
  );

  ycx_datapath #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .shadowSet(shadowSet),
    .inValid(inValid), .inReady(inReady), .inY(inY), .inCb(inCb), .inCr(inCr),
    .outValid(outValid), .outReady(outReady), .outR(outR), .outG(outG),
    .outB(outB), .pipeIdle(pipeIdle)
  );
endmodule

// File: tb/ycbcr_rgb_xform_test.sv
module ycbcr_rgb_xform_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [13:0] cfgData = '0;
  logic frameStart = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [9:0] inY = '0, inCb = '0, inCr = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [9:0] outR, outG, outB;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;
  int mdlAct[12];
  int mdlPend[12];

  always #4 clk = ~clk;

  ycbcr_rgb_xform uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .frameStart(frameStart), .inValid(inValid),
    .inReady(inReady), .inY(inY), .inCb(inCb), .inCr(inCr),
    .outValid(outValid), .outReady(outReady), .outR(outR), .outG(outG), .outB(outB)
  );

  function automatic int expCh(input int c[12], input int row, input int y,
                               input int cb, input int cr);
    int s;
    s = c[row*3] * (y - c[9]) + c[row*3+1] * (cb - c[10])
      + c[row*3+2] * (cr - c[11]) + 512;
    s = s >>> 10;
    if (s < 0) s = 0;
    if (s > 1023) s = 1023;
    return s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input int addr, input int val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 4'(addr); cfgData = 14'(val);
    @(posedge clk);
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (addr < 12) mdlPend[addr] = val;
  endtask

  task automatic idleCommit();
    repeat (3) @(negedge clk);
    mdlAct = mdlPend;
  endtask

  task automatic convertOne(input int y, input int cb, input int cr, input string req);
    @(negedge clk);
    inValid = 1'b1; inY = 10'(y); inCb = 10'(cb); inCr = 10'(cr);
    chk({req, " inReady"}, int'(inReady), 1);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk("R7 not yet valid", int'(outValid), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R7 valid after second edge", int'(outValid), 1);
    chk({req, " R"}, int'(outR), expCh(mdlAct, 0, y, cb, cr));
    chk({req, " G"}, int'(outG), expCh(mdlAct, 1, y, cb, cr));
    chk({req, " B"}, int'(outB), expCh(mdlAct, 2, y, cb, cr));
  endtask

  // Stream n pixels back to back; write (wAddr,wVal) during pixel wrAt;
  // pulse frameStart with pixel fsAt (negative = never).
  task automatic streamRun(input int n, input int wrAt, input int wAddr,
                           input int wVal, input int fsAt, input string req);
    int eR[32]; int eG[32]; int eB[32];
    int newSet[12];
    int got = 0;
    newSet = mdlAct;
    newSet[wAddr] = wVal;
    fork
      begin
        for (int i = 0; i < n; i++) begin
          int y, cb, cr;
          y = 100 + 37 * i; cb = 200 + 23 * i; cr = 700 - 19 * i;
          @(negedge clk);
          inValid = 1'b1; inY = 10'(y); inCb = 10'(cb); inCr = 10'(cr);
          cfgWrEn = (i == wrAt); cfgAddr = 4'(wAddr); cfgData = 14'(wVal);
          frameStart = (i == fsAt);
          chk("R9 inReady in stream", int'(inReady), 1);
          if (fsAt >= 0 && i > fsAt) begin
            eR[i] = expCh(newSet, 0, y, cb, cr);
            eG[i] = expCh(newSet, 1, y, cb, cr);
            eB[i] = expCh(newSet, 2, y, cb, cr);
          end else begin
            eR[i] = expCh(mdlAct, 0, y, cb, cr);
            eG[i] = expCh(mdlAct, 1, y, cb, cr);
            eB[i] = expCh(mdlAct, 2, y, cb, cr);
          end
        end
        @(negedge clk);
        inValid = 1'b0; cfgWrEn = 1'b0; frameStart = 1'b0;
      end
      begin
        for (int j = 0; j < n + 2; j++) begin
          @(negedge clk);
          if (outValid && got < n) begin
            chk({req, " R"}, int'(outR), eR[got]);
            chk({req, " G"}, int'(outG), eG[got]);
            chk({req, " B"}, int'(outB), eB[got]);
            got++;
          end
        end
      end
    join
    chk("R9 one pixel per cycle", got, n);
    mdlPend = newSet;
  endtask

  task automatic testReset();
    chk("R1 inReady after reset", int'(inReady), 1);
    chk("R1 outValid after reset", int'(outValid), 0);
    convertOne(940, 512, 512, "R1 default white");
    convertOne(502, 300, 700, "R1 default mid");
  endtask

  task automatic testFormula();
    convertOne(200, 800, 150, "R2 pattern A");
    convertOne(64, 512, 512, "R2 black");
    convertOne(513, 511, 513, "R2 rounding");
  endtask

  task automatic testClamp();
    convertOne(1023, 512, 1023, "R3 clamp high");
    convertOne(0, 512, 512, "R3 clamp low");
  endtask

  task automatic testLoad709();
    int set709[9] = '{1192, 0, 1836, 1192, -218, -546, 1192, 2163, 0};
    for (int k = 0; k < 9; k++) cfgWrite(k, set709[k]);
    idleCommit();
    convertOne(502, 300, 700, "R5 matrix order 709");
    convertOne(800, 900, 100, "R5 matrix order 709 b");
    cfgWrite(9, 0);
    idleCommit();
    convertOne(300, 400, 600, "R5 luma offset slot");
  endtask

  task automatic testNegative();
    cfgWrite(2, -1024);
    cfgWrite(11, -100);
    idleCommit();
    convertOne(512, 512, 300, "R4 negative weight");
    convertOne(600, 500, 20, "R4 negative offset");
  endtask

  task automatic testHighAddr();
    cfgWrite(12, 0);
    cfgWrite(13, 4000);
    cfgWrite(15, -1);
    repeat (3) @(negedge clk);
    convertOne(400, 450, 650, "R5 high address ignored");
  endtask

  task automatic testStreamIdle();
    streamRun(10, 1, 0, 2048, -1, "R6 busy keeps old set");
    idleCommit();
    convertOne(400, 450, 650, "R6 commit after drain");
  endtask

  task automatic testStreamFrame();
    streamRun(12, 2, 7, -1000, 6, "R6 frame start switch");
    mdlAct = mdlPend;
    convertOne(300, 300, 300, "R6 after frame start");
  endtask

  task automatic testBackpressure();
    int a[3] = '{100, 200, 900};
    int b[3] = '{700, 800, 300};
    int c[3] = '{400, 512, 512};
    @(negedge clk);
    outReady = 1'b0;
    inValid = 1'b1; inY = 10'(a[0]); inCb = 10'(a[1]); inCr = 10'(a[2]);
    @(posedge clk);
    @(negedge clk);
    inY = 10'(b[0]); inCb = 10'(b[1]); inCr = 10'(b[2]);
    chk("R8 inReady with one stage free", int'(inReady), 1);
    @(posedge clk);
    @(negedge clk);
    inY = 10'(c[0]); inCb = 10'(c[1]); inCr = 10'(c[2]);
    chk("R8 inReady low when full", int'(inReady), 0);
    for (int k = 0; k < 3; k++) begin
      chk("R8 stall valid", int'(outValid), 1);
      chk("R8 stall R", int'(outR), expCh(mdlAct, 0, a[0], a[1], a[2]));
      chk("R8 stall B", int'(outB), expCh(mdlAct, 2, a[0], a[1], a[2]));
      @(posedge clk);
      @(negedge clk);
    end
    outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk("R8 second pixel G", int'(outG), expCh(mdlAct, 1, b[0], b[1], b[2]));
    @(posedge clk);
    @(negedge clk);
    chk("R8 third pixel R", int'(outR), expCh(mdlAct, 0, c[0], c[1], c[2]));
    @(posedge clk);
    @(negedge clk);
    chk("R8 drained", int'(outValid), 0);
  endtask

  initial begin
    int d[12] = '{1192, 0, 1634, 1192, -401, -832, 1192, 2066, 0, 64, 512, 512};
    mdlAct = d;
    mdlPend = d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFormula();
    testClamp();
    testBackpressure();
    testLoad709();
    testNegative();
    testHighAddr();
    testStreamIdle();
    testStreamFrame();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule